// File: doc/BRIEF.md
# Reset-Aware Interrupt Vector Responder

This block answers the processor's vector-address bus cycle. A bus-phase decoder, which sits outside the block, raises a fetch strobe while the processor is reading a vector address. The block drives a 16-bit address onto the shared bus and enables its drivers only for the length of that strobe. At all other times it leaves the bus free.

The block picks between two addresses. It learns that the system has been reset only from the active-low master sync line. That line first passes through a synchronizer. While master sync is asserted, the block arms a one-shot "first fetch" state and drives nothing. The first vector fetch that completes after master sync is released is answered with the reset vector, $1000. Every other fetch is answered with the interrupt vector, $1004. If master sync is never seen asserted, the block keeps returning $1004.

The local `rst_n` input only initialises the flops at power-up. It clears the one-shot state and does not count as a system reset.

Top module: `vector_responder`

## Requirements
- R1: After `rst_n` is released with `msync_n` held high, `vec_oe` is 0, `vec_data` is 0, and every fetch returns $1004.
- R2: `vec_oe` is 1 only while `vec_fetch` is 1 and the synchronized master sync is deasserted. Whenever `vec_oe` is 0, `vec_data` is 0.
- R3: The first fetch that completes after master sync has been asserted and then released returns $1000.
- R4: Every fetch after that first one returns $1004, until master sync is asserted again.
- R5: While master sync is asserted, fetch strobes drive nothing and do not consume the one-shot state. The first fetch after release still returns $1000.
- R6: `msync_n` goes through a two-stage synchronizer. A low level driven before clock edge k forces `vec_oe` low after edge k+1, not earlier.
- R7: A fetch that lasts several cycles shows the same vector on every cycle. The one-shot state is consumed only when the strobe ends.
- R8: Asserting master sync again at any later time re-arms the block, so the next completed fetch returns $1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up initialisation of the flops |
| msync_n | input | 1 | Active-low master sync from the system, asynchronous to `clk` |
| vec_fetch | input | 1 | High while the decoded bus phase is a vector-address fetch |
| vec_data | output | 16 | Vector address while enabled, zero otherwise |
| vec_oe | output | 1 | Bus driver enable |

## Verification
The one-shot state can go wrong in two ways: it is lost, or it is never consumed. If it is lost, the first fetch after a master sync pulse returns $1004 instead of $1000. If it is never consumed, the second fetch returns $1000 again. Either way the error shows on `vec_data` within one fetch of the event. A synchronizer that is too short shows up on `vec_oe` one cycle early. A driver enable decoded wrongly shows up at once as bus activity outside a fetch.

// File: rtl/vector_responder_pkg.sv
package vector_responder_pkg;
  typedef enum logic {
    SEL_INTR  = 1'b0,
    SEL_RESET = 1'b1
  } vec_sel_e;
endpackage

// File: rtl/vr_sync.sv
module vr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_n,
  output logic q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d_n;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_n = chain_q[STAGES-1];
endmodule

// File: rtl/vr_first_fetch.sv
module vr_first_fetch
  import vector_responder_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sync_n_s,
  input  logic     served,
  output vec_sel_e sel
);
  logic     served_q;
  logic     fetch_done;
  logic     flag_en;
  vec_sel_e sel_q;
  vec_sel_e sel_d;

  always_comb begin
    fetch_done = served_q && !served;
    flag_en    = !sync_n_s || fetch_done;
    sel_d      = !sync_n_s ? SEL_RESET : SEL_INTR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served_q <= 1'b0;
      sel_q    <= SEL_INTR;
    end else begin
      served_q <= served;
      if (flag_en) sel_q <= sel_d;
    end
  end

  assign sel = sel_q;
endmodule

// File: rtl/vr_bus_drive.sv
module vr_bus_drive
  import vector_responder_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter logic [DATA_W-1:0] RESET_VEC = 16'h1000,
  parameter logic [DATA_W-1:0] INTR_VEC  = 16'h1004
) (
  input  logic              fetch,
  input  logic              sync_n_s,
  input  vec_sel_e          sel,
  output logic              oe,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    oe   = fetch && sync_n_s;
    data = '0;
    if (oe) data = (sel == SEL_RESET) ? RESET_VEC : INTR_VEC;
  end
endmodule

// File: rtl/vector_responder.sv
module vector_responder
  import vector_responder_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] RESET_VEC   = 16'h1000,
  parameter logic [DATA_W-1:0] INTR_VEC    = 16'h1004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msync_n,
  input  logic              vec_fetch,
  output logic [DATA_W-1:0] vec_data,
  output logic              vec_oe
);
  logic     msync_n_s;
  vec_sel_e sel;
  logic     first_flag;

  vr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_n(msync_n), .q_n(msync_n_s)
  );

  vr_first_fetch u_first (
    .clk(clk), .rst_n(rst_n), .sync_n_s(msync_n_s), .served(vec_oe), .sel(sel)
  );

  vr_bus_drive #(.DATA_W(DATA_W), .RESET_VEC(RESET_VEC), .INTR_VEC(INTR_VEC)) u_drive (
    .fetch(vec_fetch), .sync_n_s(msync_n_s), .sel(sel), .oe(vec_oe), .data(vec_data)
  );

  assign first_flag = (sel == SEL_RESET);
endmodule

// File: rtl/vector_responder_chk.sv
module vector_responder_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch,
  input logic              oe,
  input logic [DATA_W-1:0] data,
  input logic              sync_n_s,
  input logic              first_flag
);
  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |-> !oe);
  assert_quiet_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> data == '0);
  assert_sync_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_s |-> !oe);
  assert_sync_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_s |=> first_flag);
  assert_one_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe && $past(oe) && sync_n_s) |=> !first_flag);
  assert_steady_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe) && $past(rst_n)) |-> $stable(data));
  assert_legal_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (data == DATA_W'(16'h1000) || data == DATA_W'(16'h1004)));
endmodule

bind vector_responder vector_responder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch(vec_fetch), .oe(vec_oe), .data(vec_data),
  .sync_n_s(msync_n_s), .first_flag(first_flag)
);

// File: tb/vector_responder_tb.sv
module vector_responder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msync_n = 1'b1;
  logic        vec_fetch = 1'b0;
  logic [15:0] vec_data;
  logic        vec_oe;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam logic [15:0] RV = 16'h1000;
  localparam logic [15:0] IV = 16'h1004;

  always #2 clk = ~clk;

  vector_responder u_dut (
    .clk(clk), .rst_n(rst_n), .msync_n(msync_n), .vec_fetch(vec_fetch),
    .vec_data(vec_data), .vec_oe(vec_oe)
  );

  task automatic check(input string req, input logic exp_oe, input logic [15:0] exp_d);
    checks++;
    if (vec_oe !== exp_oe || vec_data !== exp_d) begin
      errors++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
               req, vec_oe, vec_data, exp_oe, exp_d);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one fetch lasting len cycles; expected vector on every cycle
  task automatic fetch(input string req, input int len, input logic [15:0] exp_d);
    @(negedge clk);
    vec_fetch = 1'b1;
    #1 check(req, 1'b1, exp_d);
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      #1 check({req, " R7 hold"}, 1'b1, exp_d);
    end
    @(negedge clk);
    vec_fetch = 1'b0;
    #1 check({req, " R2 release"}, 1'b0, 16'h0000);
  endtask

  task automatic msync_pulse(input int len);
    @(negedge clk);
    msync_n = 1'b0;
    idle(len);
    msync_n = 1'b1;
    idle(3);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: oe=%b data=%h expected run to finish", vec_oe, vec_data);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    #1 check("R1 reset", 1'b0, 16'h0000);
    rst_n = 1'b1;
    idle(2);
    #1 check("R1 idle", 1'b0, 16'h0000);
    // no master sync ever: always interrupt vector
    for (int k = 1; k <= 4; k++) fetch("R1 no-sync", k, IV);

    // basic sequence: sync, fetch, fetch, fetch
    for (int len = 1; len <= 4; len++) begin
      msync_pulse(len);
      fetch("R3 first", len, RV);
      fetch("R4 second", 1, IV);
      fetch("R4 third", 2, IV);
    end

    // fetch strobes while sync held low are not served
    @(negedge clk);
    msync_n = 1'b0;
    idle(3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      vec_fetch = 1'b1;
      #1 check("R5 sync held", 1'b0, 16'h0000);
      @(negedge clk);
      vec_fetch = 1'b0;
      #1 check("R5 sync held", 1'b0, 16'h0000);
    end
    msync_n = 1'b1;
    idle(3);
    fetch("R5 after hold", 1, RV);
    fetch("R8 later", 1, IV);

    // synchronizer latency during an active fetch
    @(negedge clk);
    vec_fetch = 1'b1;
    #1 check("R6 pre", 1'b1, IV);
    msync_n = 1'b0;
    @(negedge clk);
    #1 check("R6 one edge", 1'b1, IV);
    @(negedge clk);
    #1 check("R6 two edges", 1'b0, 16'h0000);
    msync_n = 1'b1;
    @(negedge clk);
    #1 check("R6 release one edge", 1'b0, 16'h0000);
    @(negedge clk);
    #1 check("R6 release two edges", 1'b1, RV);
    @(negedge clk);
    vec_fetch = 1'b0;
    #1 check("R2 end", 1'b0, 16'h0000);
    fetch("R4 after R6", 1, IV);

    // re-arm once more
    msync_pulse(1);
    fetch("R8 rearm", 3, RV);
    fetch("R4 final", 1, IV);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule